// File: doc/BRIEF.md
# Multi-format stereo serial audio receiver

This block takes stereo audio words of up to 16 bits from a bit-serial link and presents each left/right pair as two parallel signed samples. A static format input chooses between two single-line, time-multiplexed formats (framed by a word-select line, one carrying offset binary and one carrying two's complement) and a two-line simultaneous format (framed by a latch strobe, offset binary). All link inputs are brought into the system clock domain through synchronizers, and all edge detection happens there. The system clock must run at least four times faster than the bit clock.

Samples leave the block as a stream with a one-cycle `smp_valid` strobe. There is no ready input: the serial source cannot be stalled, so there is no back-pressure. A consumer must take the pair in the strobe cycle, or read the held outputs before the next strobe. The outputs keep their value between strobes. The format input must only change while reset is asserted.

Top module: `stereo_serial_rx`

## Requirements
- R1: `fmt` encoding: 0 is time-multiplexed offset binary, 1 is time-multiplexed two's complement, and 2 or 3 (`fmt[1]` set) is simultaneous offset binary. In simultaneous mode `sdata_l` feeds the left word and `sdata_r` feeds the right word. In time-multiplexed modes both words come from `sdata_l` and `sdata_r` is unused.
- R2: In time-multiplexed modes, frame low marks the left word and frame high marks the right word. Each bit is sampled on a bit-clock rising edge. The frame line changes one bit ahead of the word it announces, so the bit sampled at the rising edge where a new frame level is first seen is the last bit of the previous word.
- R3: In time-multiplexed modes, a new pair is committed on the first bit-clock rising edge after frame falls, which is the rising edge that samples the last bit of the right word.
- R4: In simultaneous mode, both lines shift in together on bit-clock rising edges. On a rising edge of the latch strobe, the last 16 bits shifted in on each line become the pair. Frames of 16 or more bits are supported.
- R5: Offset-binary input is converted to two's complement by inverting bit 15, so both outputs are always signed two's complement.
- R6: Every serial word is sent MSB first. A time-multiplexed word shorter than 16 bits is left-aligned, and its low bits are filled with zero.
- R7: In a time-multiplexed word, any bits after the sixteenth are ignored, and the output holds the first 16 bits received.
- R8: After reset, both outputs are zero and `smp_valid` is low. In time-multiplexed modes, no strobe is issued until the frame line has shown a falling boundary and then a rising boundary, so the first pair is built from complete words.
- R9: `smp_valid` is high for exactly one system clock per committed pair. The outputs change only in the cycle that `smp_valid` is high, and exactly one strobe is issued per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Static format select (R1 encoding) |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| frame_in | input | 1 | Word select (time-multiplexed modes) or latch strobe (simultaneous mode) |
| sdata_l | input | 1 | Left data line, or the single data line in time-multiplexed modes |
| sdata_r | input | 1 | Right data line, simultaneous mode only |
| left_smp | output | 16 | Left sample, two's complement |
| right_smp | output | 16 | Right sample, two's complement |
| smp_valid | output | 1 | One-cycle strobe when a new pair appears, no ready |

## Verification
Two behaviours are hard to reach from the ports. The first is the rising edge where the frame level flips: the bit sampled there closes the old word, and if the frame is the falling kind, it also commits the pair. The second is the first frame after reset, which must not produce a strobe. The stimulus sends a dummy right word straight after reset to walk through that start-up history. It then sends a continuous stream in which every word length from 1 to 20 bits appears in each time-multiplexed format, so the short, exactly 16-bit and over-long cases all land on that boundary edge. Simultaneous mode is swept over frames of 16 to 24 bits, so that the dropped leading bits are exercised.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    FMT_TDM_OFFSET  = 2'd0,
    FMT_TDM_TWOS    = 2'd1,
    FMT_PAR_OFFSET  = 2'd2,
    FMT_PAR_OFFSET2 = 2'd3
  } srx_fmt_e;

  function automatic logic fmt_is_parallel(input logic [1:0] f);
    return f[1];
  endfunction

  function automatic logic fmt_is_offset(input logic [1:0] f);
    return f != FMT_TDM_TWOS;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2,
  parameter int N_EDGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  din,
  output logic [N-1:0]  lvl,
  output logic [N_EDGE-1:0] rise
);
  logic [N-1:0] pipe [STAGES];
  logic [N_EDGE-1:0] prv;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prv <= '0;
    else        prv <= pipe[STAGES-1][N_EDGE-1:0];
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1][N_EDGE-1:0] & ~prv;
endmodule

// File: rtl/srx_lane.sv
module srx_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_mode,
  input  logic         bit_stb,
  input  logic         bit_val,
  input  logic         sel,
  input  logic         word_end,
  input  logic         capture,
  output logic [W-1:0] word_hold
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, acc_next;
  logic [CW-1:0] cnt;

  always_comb begin
    acc_next = acc;
    if (par_mode) begin
      acc_next = {acc[W-2:0], bit_val};
    end else begin
      for (int i = 0; i < W; i++) begin
        if (cnt == CW'(W - 1 - i)) acc_next[i] = bit_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      word_hold <= '0;
    end else begin
      if (bit_stb && (par_mode || sel)) begin
        if (!par_mode && word_end) begin
          word_hold <= acc_next;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc_next;
          if (!par_mode && cnt < CW'(W)) cnt <= cnt + 1'b1;
        end
      end
      if (capture && par_mode) word_hold <= acc;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));
endmodule

// File: rtl/srx_frame_ctl.sv
module srx_frame_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_mode,
  input  logic       bclk_rise,
  input  logic       frm_lvl,
  input  logic       frm_rise,
  output logic [1:0] lane_sel,
  output logic       word_end,
  output logic       capture,
  output logic       commit
);
  logic       ws_prev, have_prev, tgt;
  logic [1:0] bnd_cnt;

  assign tgt      = have_prev ? ws_prev : frm_lvl;
  assign lane_sel = {tgt, ~tgt};
  assign word_end = !par_mode && have_prev && (frm_lvl != ws_prev);
  assign capture  = par_mode && frm_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_prev   <= 1'b0;
      have_prev <= 1'b0;
      bnd_cnt   <= '0;
      commit    <= 1'b0;
    end else begin
      commit <= capture ||
                (bclk_rise && word_end && ws_prev && bnd_cnt == 2'd2);
      if (bclk_rise && !par_mode) begin
        ws_prev   <= frm_lvl;
        have_prev <= 1'b1;
        if (word_end && bnd_cnt != 2'd2) bnd_cnt <= bnd_cnt + 2'd1;
      end
    end
  end

  assert_commit_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(bclk_rise || frm_rise));
  assert_no_early_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !par_mode) |-> $past(bnd_cnt == 2'd2));
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import srx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt,
  input  logic                bclk_in,
  input  logic                frame_in,
  input  logic                sdata_l,
  input  logic                sdata_r,
  output logic [SAMPLE_W-1:0] left_smp,
  output logic [SAMPLE_W-1:0] right_smp,
  output logic                smp_valid
);
  localparam int NUM_IN    = 4;
  localparam int NUM_EDGE  = 2;
  localparam int NUM_LANES = 2;
  localparam int IDX_BCLK  = 0;
  localparam int IDX_FRM   = 1;
  localparam int IDX_DL    = 2;
  localparam int IDX_DR    = 3;
  localparam logic [SAMPLE_W-1:0] MSB_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [NUM_IN-1:0]   s_lvl;
  logic [NUM_EDGE-1:0] s_rise;
  logic                par_mode;
  logic [1:0]          lane_sel;
  logic                word_end, capture, commit;
  logic [SAMPLE_W-1:0] lane_word [NUM_LANES];
  logic [SAMPLE_W-1:0] flip;

  assign par_mode = fmt_is_parallel(fmt);
  assign flip     = fmt_is_offset(fmt) ? MSB_MASK : '0;

  srx_sync #(.N(NUM_IN), .STAGES(SYNC_STAGES), .N_EDGE(NUM_EDGE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sdata_r, sdata_l, frame_in, bclk_in}),
    .lvl  (s_lvl),
    .rise (s_rise)
  );

  srx_frame_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .bclk_rise(s_rise[IDX_BCLK]),
    .frm_lvl  (s_lvl[IDX_FRM]),
    .frm_rise (s_rise[IDX_FRM]),
    .lane_sel (lane_sel),
    .word_end (word_end),
    .capture  (capture),
    .commit   (commit)
  );

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    logic bit_src;
    if (c == 0) begin : g_l
      assign bit_src = s_lvl[IDX_DL];
    end else begin : g_r
      assign bit_src = par_mode ? s_lvl[IDX_DR] : s_lvl[IDX_DL];
    end
    srx_lane #(.W(SAMPLE_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .par_mode (par_mode),
      .bit_stb  (s_rise[IDX_BCLK]),
      .bit_val  (bit_src),
      .sel      (lane_sel[c]),
      .word_end (word_end),
      .capture  (capture),
      .word_hold(lane_word[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_smp  <= '0;
      right_smp <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= commit;
      if (commit) begin
        left_smp  <= lane_word[0] ^ flip;
        right_smp <= lane_word[1] ^ flip;
      end
    end
  end

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  assert_left_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (left_smp != $past(left_smp)) |-> smp_valid);
  assert_right_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (right_smp != $past(right_smp)) |-> smp_valid);
endmodule

// File: tb/stereo_serial_rx_test.sv
module stereo_serial_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        bclk_in = 1'b0, frame_in = 1'b0, sdata_l = 1'b0, sdata_r = 1'b0;
  logic [15:0] left_smp, right_smp;
  logic        smp_valid;

  int n_run = 0, n_fail = 0, strobes = 0, cyc = 0;
  bit done = 1'b0;
  logic [15:0] cap_l = '0, cap_r = '0;
  logic [31:0] rng = 32'h1234_5678;

  stereo_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bclk_in(bclk_in), .frame_in(frame_in),
    .sdata_l(sdata_l), .sdata_r(sdata_r),
    .left_smp(left_smp), .right_smp(right_smp), .smp_valid(smp_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      strobes <= strobes + 1;
      cap_l   <= left_smp;
      cap_r   <= right_smp;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_LIMIT && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R3: actual hung expected completion");
      summary();
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic send_bit(logic f, logic a, logic b);
    @(posedge clk);
    frame_in = f; sdata_l = a; sdata_r = b;
    idle(HALF_BIT);
    bclk_in = 1'b1;
    idle(HALF_BIT);
    bclk_in = 1'b0;
  endtask

  task automatic tdm_word(logic [31:0] w, int len, logic lvl, logic nxt);
    for (int i = 0; i < len; i++)
      send_bit((i == len - 1) ? nxt : lvl, w[len-1-i], 1'b0);
  endtask

  function automatic logic [31:0] exp_tdm(logic [31:0] w, int len, bit ob);
    logic [31:0] v;
    v = (len >= 16) ? (w >> (len - 16)) : (w << (16 - len));
    return {16'h0, v[15:0] ^ (ob ? 16'h8000 : 16'h0)};
  endfunction

  task automatic do_reset(logic [1:0] f);
    rst_n = 1'b0; fmt = f;
    bclk_in = 1'b0; frame_in = 1'b0; sdata_l = 1'b0; sdata_r = 1'b0;
    idle(6);
    @(negedge clk);
    check("R8 reset left", {16'h0, left_smp}, 32'h0);
    check("R8 reset right", {16'h0, right_smp}, 32'h0);
    check("R8 reset strobe", {31'h0, smp_valid}, 32'h0);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      do_reset(2'(m));
      // dummy right word: its framing history must not cause a strobe (R8)
      tdm_word(32'h0000_A5A5, 16, 1'b1, 1'b0);
      for (int len = 1; len <= 20; len++) begin
        int s0;
        logic [31:0] lw, rw, mask;
        mask = (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
        rng = next_rand(rng); lw = rng & mask;
        rng = next_rand(rng); rw = rng & mask;
        s0 = strobes;
        tdm_word(lw, len, 1'b0, 1'b1);
        idle(6);
        check("R8 no strobe before right word ends", 32'(strobes), 32'(s0));
        tdm_word(rw, len, 1'b1, 1'b0);
        idle(8);
        check("R9 one strobe per pair", 32'(strobes), 32'(s0 + 1));
        if (len < 16) begin
          check("R6 short left word (R2 R5 R1)", {16'h0, cap_l}, exp_tdm(lw, len, m == 0));
          check("R6 short right word (R2 R5 R1)", {16'h0, cap_r}, exp_tdm(rw, len, m == 0));
        end else if (len == 16) begin
          check("R3 full left word (R2 R5 R1)", {16'h0, cap_l}, exp_tdm(lw, len, m == 0));
          check("R3 full right word (R2 R5 R1)", {16'h0, cap_r}, exp_tdm(rw, len, m == 0));
        end else begin
          check("R7 long left word", {16'h0, cap_l}, exp_tdm(lw, len, m == 0));
          check("R7 long right word", {16'h0, cap_r}, exp_tdm(rw, len, m == 0));
        end
      end
    end

    for (int m = 2; m < 4; m++) begin
      do_reset(2'(m));
      for (int len = 16; len <= ((m == 2) ? 24 : 18); len++) begin
        int s0;
        logic [31:0] lw, rw;
        rng = next_rand(rng); lw = rng;
        rng = next_rand(rng); rw = rng;
        s0 = strobes;
        for (int i = 0; i < len; i++) send_bit(1'b0, lw[len-1-i], rw[len-1-i]);
        idle(6);
        check("R4 no strobe before latch edge", 32'(strobes), 32'(s0));
        @(posedge clk); frame_in = 1'b1;
        idle(6);
        frame_in = 1'b0;
        idle(6);
        check("R9 one strobe per latch", 32'(strobes), 32'(s0 + 1));
        check("R4 simultaneous left (R5 R1)", {16'h0, cap_l}, {16'h0, lw[15:0] ^ 16'h8000});
        check("R4 simultaneous right (R5 R1)", {16'h0, cap_r}, {16'h0, rw[15:0] ^ 16'h8000});
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule